// File: doc/BRIEF.md
# Iterative Integer Divide/Remainder Unit

This unit performs integer division and remainder for a processor execute stage, one quotient bit per clock. A request is a single-cycle pulse with two operands, a destination register number and five flags: signedness, half-width (word) operation, extended dividend, remainder instead of quotient, and record-condition. After a fixed number of cycles the unit returns a one-cycle result carrying a register write enable, the echoed register number and the result data. When record-condition was set, it also writes a condition field that classifies the result as negative, positive or zero.

Signed operands arrive in two's complement. When a signed request has a negative effective operand, the unit spends one extra cycle converting the negative operands to magnitudes before it iterates. It then restores the sign of the quotient or remainder in the result cycle. Division by zero and quotient overflow produce implementation-defined data, but they keep the normal timing. Only one operation is in flight at a time. The issuing stage watches `busy`, and the unit drops any request that arrives while it is occupied.

Top module: `divu_top`

## Requirements
- R1: While reset is asserted and after it is released, `res_vld`, `cond_wen` and `busy` are low until a request is accepted.
- R2: Count the accepting clock edge as edge 0. `res_vld` is high for exactly one cycle, the one following edge DW. If the negation cycle is taken, that becomes edge DW+1. `res_vld` is low in every other cycle, including the one right after the request.
- R3: When `req_sgn`=0 and the request is full width and not extended, the result is the truncated unsigned quotient. With `req_mod`=1 it is the unsigned remainder instead.
- R4: When `req_sgn`=1 and the request is full width and not extended, the quotient truncates toward zero and the remainder takes the sign of the dividend. The negation cycle is taken when either operand's top bit is set.
- R5: With `req_ext`=1 on a full-width request, the dividend is `req_dend` times 2^DW. The result is the low DW bits of the quotient, and it is defined whenever that quotient fits in DW bits (signed or unsigned range as selected).
- R6: With `req_word`=1, only the low DW/2 result bits are defined. The divisor is the low half of `req_dsor`, sign- or zero-extended. The dividend is the low half of `req_dend`, extended the same way. If `req_ext` is also set, the dividend is instead the upper half of `req_dend` followed by DW/2 zero bits.
- R7: The result cycle asserts `res_wen` and presents the request's register number unchanged on `res_rnum`.
- R8: When `req_rec` was set, the result cycle asserts `cond_wen` with `cond_mask`=8'b1000_0000. `cond_data[31:28]` is 4'b1000 for a negative result, 4'b0100 for a positive one and 4'b0010 for zero, and `cond_data[27:0]` is zero. The result is judged as signed: all DW bits are used, or the low half sign-extended in word mode.
- R9: When `req_rec` was clear, `cond_wen` stays low in the result cycle.
- R10: A request that arrives while `busy` is high, including during the result cycle, is ignored. It changes neither the pending result nor its register number, and it produces no later result.
- R11: A zero divisor completes with the same R2 timing and leaves the unit ready for the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request pulse, taken only when idle |
| req_dend | input | DW | Dividend operand |
| req_dsor | input | DW | Divisor operand |
| req_rnum | input | RW | Destination register number |
| req_sgn | input | 1 | Signed operation |
| req_word | input | 1 | Half-width operation |
| req_ext | input | 1 | Extended (shifted) dividend |
| req_mod | input | 1 | Return remainder instead of quotient |
| req_rec | input | 1 | Also write the condition field |
| busy | output | 1 | An operation is in flight |
| res_vld | output | 1 | Result cycle |
| res_wen | output | 1 | Register write enable |
| res_rnum | output | RW | Echoed register number |
| res_data | output | DW | Quotient or remainder |
| cond_wen | output | 1 | Condition field write enable |
| cond_mask | output | 8 | Condition field select mask |
| cond_data | output | 32 | Condition code in the top nibble |

## Verification
Two functions can collide in one cycle. A new request can arrive in the same cycle the unit emits its result, and it can also arrive while the iteration is running. The bench provokes both. It pulses a second request with a different register number a few cycles into an operation, and again exactly in the cycle where `res_vld` is high. It then judges that the first result still carries its own data and register number, and that no further result appears in the following two full operation lengths. The arithmetic sweeps run at DW=8, where every mode can be compared against quotients and remainders computed with plain integer arithmetic.

// File: rtl/divu_pkg.sv
package divu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NEG  = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } div_state_e;

  // flags kept for the whole operation
  typedef struct packed {
    logic word;
    logic ext;
    logic md;
    logic rec;
  } op_flags_t;

  localparam logic [3:0] CMP_LT = 4'b1000;
  localparam logic [3:0] CMP_GT = 4'b0100;
  localparam logic [3:0] CMP_EQ = 4'b0010;
  localparam logic [7:0] COND_FIELD0 = 8'b1000_0000;

endpackage

// File: rtl/divu_operand.sv
module divu_operand #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] raw_a,
  input  logic [DW-1:0] raw_b,
  input  logic          sgn,
  input  logic          word,
  input  logic          ext,
  output logic [DW-1:0] eff_a,
  output logic [DW-1:0] eff_b,
  output logic          neg_a,
  output logic          neg_b
);
  localparam int HW = DW / 2;

  always_comb begin
    if (!word) begin
      eff_a = raw_a;
      eff_b = raw_b;
    end else begin
      // word extended: upper half is the operand, low half zero
      eff_a = ext ? {raw_a[DW-1:HW], {HW{1'b0}}}
                  : {{HW{sgn & raw_a[HW-1]}}, raw_a[HW-1:0]};
      eff_b = {{HW{sgn & raw_b[HW-1]}}, raw_b[HW-1:0]};
    end
    neg_a = sgn & eff_a[DW-1];
    neg_b = sgn & eff_b[DW-1];
  end
endmodule

// File: rtl/divu_step.sv
module divu_step #(
  parameter int DW = 64
) (
  input  logic [DW:0]   rem_i,
  input  logic [DW-1:0] quo_i,
  input  logic [DW-1:0] dsor_i,
  output logic [DW:0]   rem_o,
  output logic [DW-1:0] quo_o
);
  logic [DW+1:0] shifted;
  logic [DW+1:0] trial;

  always_comb begin
    shifted = {rem_i, quo_i[DW-1]};
    trial   = shifted - {2'b00, dsor_i};
    if (!trial[DW+1]) begin
      rem_o = trial[DW:0];
      quo_o = {quo_i[DW-2:0], 1'b1};
    end else begin
      rem_o = shifted[DW:0];
      quo_o = {quo_i[DW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/divu_result.sv
module divu_result
  import divu_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] quo,
  input  logic [DW-1:0] rem,
  input  logic          neg_q,
  input  logic          neg_r,
  input  logic          md,
  input  logic          word,
  output logic [DW-1:0] data,
  output logic [3:0]    code
);
  localparam int HW = DW / 2;
  logic [DW-1:0] cmpv;

  always_comb begin
    if (md) data = neg_r ? -rem : rem;
    else    data = neg_q ? -quo : quo;
    cmpv = word ? {{HW{data[HW-1]}}, data[HW-1:0]} : data;
    if (cmpv == '0)       code = CMP_EQ;
    else if (cmpv[DW-1])  code = CMP_LT;
    else                  code = CMP_GT;
  end
endmodule

// File: rtl/divu_top.sv
module divu_top
  import divu_pkg::*;
#(
  parameter int DW = 64,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [DW-1:0] req_dend,
  input  logic [DW-1:0] req_dsor,
  input  logic [RW-1:0] req_rnum,
  input  logic          req_sgn,
  input  logic          req_word,
  input  logic          req_ext,
  input  logic          req_mod,
  input  logic          req_rec,
  output logic          busy,
  output logic          res_vld,
  output logic          res_wen,
  output logic [RW-1:0] res_rnum,
  output logic [DW-1:0] res_data,
  output logic          cond_wen,
  output logic [7:0]    cond_mask,
  output logic [31:0]   cond_data
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  div_state_e    state_q, state_d;
  logic [DW:0]   rem_q, rem_d, step_rem;
  logic [DW-1:0] quo_q, quo_d, step_quo, dsor_q, dsor_d;
  logic [CW-1:0] cnt_q, cnt_d;
  op_flags_t     flags_q;
  logic          neg_a_q, neg_b_q;
  logic [RW-1:0] rnum_q;

  logic [DW-1:0] eff_a, eff_b, src_a, src_b, fin_data;
  logic          neg_a, neg_b, in_neg, wide, load, cap_en, dp_en;
  logic [3:0]    code;

  divu_operand #(.DW(DW)) u_operand (
    .raw_a(req_dend), .raw_b(req_dsor), .sgn(req_sgn), .word(req_word),
    .ext(req_ext), .eff_a(eff_a), .eff_b(eff_b), .neg_a(neg_a), .neg_b(neg_b)
  );

  divu_step #(.DW(DW)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .dsor_i(dsor_q),
    .rem_o(step_rem), .quo_o(step_quo)
  );

  divu_result #(.DW(DW)) u_result (
    .quo(quo_q), .rem(rem_q[DW-1:0]), .neg_q(neg_a_q ^ neg_b_q),
    .neg_r(neg_a_q), .md(flags_q.md), .word(flags_q.word),
    .data(fin_data), .code(code)
  );

  // next-state and datapath selection
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dsor_d  = dsor_q;
    cnt_d   = cnt_q;
    cap_en  = 1'b0;
    load    = 1'b0;
    in_neg  = (state_q == ST_NEG);
    // in the negation cycle the raw dividend sits in the quotient register
    src_a   = in_neg ? (neg_a_q ? -quo_q : quo_q) : eff_a;
    src_b   = in_neg ? (neg_b_q ? -dsor_q : dsor_q) : eff_b;
    wide    = in_neg ? (flags_q.ext & ~flags_q.word) : (req_ext & ~req_word);
    case (state_q)
      ST_IDLE: begin
        if (req_vld) begin
          cap_en = 1'b1;
          if (neg_a | neg_b) begin
            state_d = ST_NEG;
            quo_d   = eff_a;
            dsor_d  = eff_b;
          end else begin
            load    = 1'b1;
            state_d = ST_RUN;
          end
        end
      end
      ST_NEG: begin
        load    = 1'b1;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        rem_d = step_rem;
        quo_d = step_quo;
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == LAST) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (load) begin
      rem_d  = wide ? {1'b0, src_a} : '0;
      quo_d  = wide ? '0 : src_a;
      dsor_d = src_b;
      cnt_d  = '0;
    end
    dp_en = cap_en | in_neg | (state_q == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (dp_en) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dsor_q <= dsor_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      flags_q <= '{word: req_word, ext: req_ext, md: req_mod, rec: req_rec};
      neg_a_q <= neg_a;
      neg_b_q <= neg_b;
      rnum_q  <= req_rnum;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign res_vld   = (state_q == ST_DONE);
  assign res_wen   = res_vld;
  assign res_rnum  = rnum_q;
  assign res_data  = fin_data;
  assign cond_wen  = res_vld & flags_q.rec;
  assign cond_mask = cond_wen ? COND_FIELD0 : 8'h00;
  assign cond_data = cond_wen ? {code, 28'h0} : 32'h0;

  // R2: nothing comes out in the cycle after an accepted request
  a_r2_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !busy) |=> !res_vld);
  // R2: the result is a single-cycle pulse
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);
  // R2: a result is only ever preceded by work in progress
  a_r2_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(busy));
  // R10: a request during an operation leaves the pending register number alone
  a_r10_hold_rnum: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_vld) |=> $stable(res_rnum));
  // R8: exactly one of the three classification bits, rest of the word clear
  a_r8_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
    cond_wen |-> ($countones(cond_data[31:28]) == 1 && cond_data[27:0] == 28'h0));
  // R8: a zero full-width result is reported as equal
  a_r8_zero_is_eq: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_wen && res_data == '0) |-> cond_data[29]);
endmodule

// File: tb/divu_top_tb.sv
module divu_top_tb;
  localparam int DW = 8;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_vld;
  logic [DW-1:0] req_dend, req_dsor;
  logic [RW-1:0] req_rnum;
  logic          req_sgn, req_word, req_ext, req_mod, req_rec;
  logic          busy, res_vld, res_wen, cond_wen;
  logic [RW-1:0] res_rnum;
  logic [DW-1:0] res_data;
  logic [7:0]    cond_mask;
  logic [31:0]   cond_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // sampled by issue()
  int          o_lat;
  logic [7:0]  o_data;
  logic [4:0]  o_rnum;
  logic        o_wen, o_cw, o_post, o_busy;
  logic [7:0]  o_cm;
  logic [31:0] o_cd;

  always #5 clk = ~clk;

  divu_top #(.DW(DW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dend(req_dend),
    .req_dsor(req_dsor), .req_rnum(req_rnum), .req_sgn(req_sgn),
    .req_word(req_word), .req_ext(req_ext), .req_mod(req_mod), .req_rec(req_rec),
    .busy(busy), .res_vld(res_vld), .res_wen(res_wen), .res_rnum(res_rnum),
    .res_data(res_data), .cond_wen(cond_wen), .cond_mask(cond_mask),
    .cond_data(cond_data)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int s8(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic int s4(input int x);
    return (x >= 8) ? x - 16 : x;
  endfunction

  // arithmetic model; def=0 marks an implementation-defined outcome
  function automatic void model(input int a, input int b, input bit sg, input bit wd,
                                input bit ex, input bit md, output bit def, output int val);
    int av, bv, w, q;
    if (!wd) begin
      av = sg ? s8(a) : a;
      bv = sg ? s8(b) : b;
      if (ex) av = av * 256;
      w = 8;
    end else begin
      if (ex) av = sg ? s8(a & 'hF0) : (a & 'hF0);
      else    av = sg ? s4(a & 'hF) : (a & 'hF);
      bv = sg ? s4(b & 'hF) : (b & 'hF);
      w = 4;
    end
    def = (bv != 0);
    val = 0;
    if (def) begin
      q = av / bv;
      if (md) val = av % bv;
      else begin
        val = q;
        if (sg) def = (q >= -(1 << (w - 1))) && (q < (1 << (w - 1)));
        else    def = (q < (1 << w));
      end
    end
  endfunction

  task automatic issue(input logic [7:0] a, input logic [7:0] b, input bit sg,
                       input bit wd, input bit ex, input bit md, input bit rc,
                       input logic [4:0] rn);
    @(negedge clk);
    req_dend = a; req_dsor = b; req_sgn = sg; req_word = wd; req_ext = ex;
    req_mod = md; req_rec = rc; req_rnum = rn; req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    o_lat = 1;
    while (!res_vld && o_lat < 3 * DW) begin
      @(negedge clk);
      o_lat++;
    end
    o_data = res_data; o_rnum = res_rnum; o_wen = res_wen;
    o_cw = cond_wen; o_cm = cond_mask; o_cd = cond_data;
    @(negedge clk);
    o_post = res_vld;
    o_busy = busy;
  endtask

  task automatic run_one(input int a, input int b, input bit sg, input bit wd,
                         input bit ex, input bit md);
    bit def, rc, negx;
    int val, w, x, code, exp_lat;
    string rq;
    logic [4:0] rn;
    rc = ((a + b) & 1) == 1;
    rn = 5'((a ^ (b >> 1)) & 31);
    issue(8'(a), 8'(b), sg, wd, ex, md, rc, rn);
    negx = sg && (((wd && !ex) ? a[3] : a[7]) || (wd ? b[3] : b[7]));
    exp_lat = DW + 1 + (negx ? 1 : 0);
    rq = wd ? "R6" : (ex ? "R5" : (sg ? "R4" : "R3"));
    if (b == 0) check(o_lat == exp_lat, "R11", "zero-divisor latency", o_lat, exp_lat);
    else        check(o_lat == exp_lat, "R2", "latency", o_lat, exp_lat);
    check(o_post == 1'b0 && o_busy == 1'b0, "R2", "pulse end / idle", {o_post, o_busy}, 0);
    check(o_wen == 1'b1 && o_rnum == rn, "R7", "wen/rnum", {o_wen, o_rnum}, {1'b1, rn});
    model(a, b, sg, wd, ex, md, def, val);
    w = wd ? 4 : 8;
    if (def) begin
      x = val & ((1 << w) - 1);
      check(int'(o_data) % (1 << w) == x, rq, md ? "remainder" : "quotient",
            int'(o_data) % (1 << w), x);
    end
    if (rc) begin
      check(o_cw == 1'b1 && o_cm == 8'h80, "R8", "cond enable/mask", {o_cw, o_cm}, 9'h180);
      if (def) begin
        x = val & ((1 << w) - 1);
        code = (x == 0) ? 2 : (((x >> (w - 1)) & 1) == 1 ? 8 : 4);
        check(o_cd == 32'(code) << 28, "R8", "cond code", o_cd, 32'(code) << 28);
      end
    end else begin
      check(o_cw == 1'b0, "R9", "cond enable without record", o_cw, 0);
    end
  endtask

  task automatic sweep(input bit sg, input bit wd, input bit ex, input bit md);
    for (int a = 0; a < 256; a += 9)
      for (int b = 0; b < 256; b += 11)
        run_one(a, b, sg, wd, ex, md);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(185000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int extra;
    rst_n = 1'b0; req_vld = 1'b0; req_dend = '0; req_dsor = '0; req_rnum = '0;
    req_sgn = 0; req_word = 0; req_ext = 0; req_mod = 0; req_rec = 0;
    repeat (3) @(negedge clk);
    check(res_vld == 0 && cond_wen == 0 && busy == 0, "R1", "in reset",
          {res_vld, cond_wen, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(res_vld == 0 && cond_wen == 0 && busy == 0, "R1", "after reset",
          {res_vld, cond_wen, busy}, 0);

    // corners around the most negative value
    run_one(128, 255, 1, 0, 0, 0);
    run_one(128, 1, 1, 0, 0, 0);
    run_one(128, 128, 1, 0, 0, 1);
    run_one(127, 255, 1, 0, 0, 1);
    run_one(8, 15, 1, 1, 0, 0);
    run_one(0, 0, 0, 0, 0, 0);

    for (int s = 0; s < 2; s++) begin
      sweep(s[0], 0, 0, 0);
      sweep(s[0], 0, 0, 1);
      sweep(s[0], 0, 1, 0);
      sweep(s[0], 1, 0, 0);
      sweep(s[0], 1, 0, 1);
      sweep(s[0], 1, 1, 0);
    end

    // R10: requests while busy and in the result cycle
    @(negedge clk);
    req_dend = 8'd100; req_dsor = 8'd7; req_rnum = 5'd3; req_sgn = 0; req_word = 0;
    req_ext = 0; req_mod = 0; req_rec = 0; req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    repeat (3) @(negedge clk);
    req_dend = 8'd5; req_dsor = 8'd1; req_rnum = 5'd9; req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    extra = 0;
    while (!res_vld && extra < 3 * DW) begin
      @(negedge clk);
      extra++;
    end
    check(res_vld == 1'b1 && res_data == 8'd14, "R10", "first result kept", res_data, 14);
    check(res_rnum == 5'd3, "R10", "first rnum kept", res_rnum, 3);
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    extra = 0;
    repeat (2 * DW + 4) begin
      if (res_vld) extra++;
      @(negedge clk);
    end
    check(extra == 0, "R10", "results from ignored requests", extra, 0);
    check(busy == 1'b0, "R10", "idle afterwards", busy, 0);

    finish_run();
  end
endmodule